// File: doc/BRIEF.md
# Run-Time Programmable Transposed FIR Filter

This block is an N-tap FIR filter in transposed form whose taps can be rewritten while it runs. Each tap stores its coefficient as a sign bit plus an unsigned magnitude. One shared generator forms the odd multiples 1, 3, 5, …, 15 of the current input sample. Each tap then builds magnitude × sample without a multiplier. It splits the magnitude into 4-bit digits, picks one odd multiple per digit and shifts it into place. The sign bit turns the tap's structural adder into a subtractor, so the product logic only ever handles unsigned magnitudes.

Samples arrive with a one-cycle valid strobe. The filtered result is registered and comes out one cycle later with its own valid flag. Coefficients are written one tap at a time through a small write port that carries a tap index, a sign and a magnitude. Partial sums already in the delay chain are kept when a coefficient changes, so a change spreads into the output over the following samples.

Top module: `prog_fir_tf`

## Requirements
- R1: A synchronous active-high `rst` clears every delay register, the output register, `out_valid` and all stored coefficients (to +0). After reset, a sample produces an output that contains only contributions from samples that arrived after the reset.
- R2: `out_valid` is high in exactly the cycle after a cycle where `in_valid` was high. It is low in every other cycle.
- R3: For every strobed sample n, `out_sample` equals the sum over taps k = 0 … N-1 of c_k·x[n-k]. Both `in_sample` and `out_sample` are two's complement, and x[m] is the m-th strobed sample, with zero before the first sample after reset. Tap 0 weights the newest sample.
- R4: A tap with `coef_neg` = 1 contributes −magnitude × sample. A negative zero (sign 1, magnitude 0) contributes nothing.
- R5: A coefficient written in cycle t (`coef_we` = 1, tap `coef_idx`) is used for samples strobed after cycle t. A sample strobed in cycle t itself still uses the old value. Partial sums already in the chain keep the coefficient values that were current when their samples entered.
- R6: The accumulator is DATA_W+MAG_W+clog2(N)+1 bits wide and never overflows, including when every tap holds magnitude 255 and the input is −128 for N samples in a row.
- R7: While `in_valid` is low, `out_sample` holds its value and the delay chain does not move, whatever `in_sample`, `coef_neg` or `coef_mag` carry.
- R8: Each tap's product equals magnitude × sample for every magnitude in 0 … 255, built only from the shared odd multiples, shifts and adds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_sample` holds a new sample |
| in_sample | input | DATA_W (8) | Input sample, two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | clog2(N_TAPS) (3) | Tap to write |
| coef_neg | input | 1 | Sign of the written coefficient (1 = negative) |
| coef_mag | input | MAG_W (8) | Unsigned magnitude of the written coefficient |
| out_valid | output | 1 | `out_sample` was updated by the previous strobe |
| out_sample | output | ACC_W (20) | Filter output, two's complement |

## Verification
The hardest case to reach is a delay chain that holds partial sums built under several generations of coefficients at once. This happens when writes land between samples and when a write coincides with a sample strobe. Sample-by-sample output alone cannot show this unless the reference model tracks which coefficient set each sample entered under. The bench keeps, for every sample in its history window, a snapshot of the coefficient set that was current when that sample arrived. It then mixes random writes, including writes in the same cycle as a strobe, into a random sample stream with idle gaps. Directed impulses, sign flips, negative zero and full-scale inputs cover the product and width corners.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // width of one magnitude digit handled by a single odd-multiple select
  localparam int unsigned DIG_W = 4;

  // position of the lowest set bit of a nonzero digit
  function automatic int unsigned dig_shift(input logic [DIG_W-1:0] d);
    int unsigned r;
    r = 0;
    for (int i = DIG_W - 1; i >= 0; i--) begin
      if (d[i]) r = i;
    end
    return r;
  endfunction

  // index into the odd-multiple table: (odd part - 1) / 2
  function automatic int unsigned dig_odd_idx(input logic [DIG_W-1:0] d);
    int unsigned v;
    v = int'(d) >> dig_shift(d);
    return v >> 1;
  endfunction

endpackage

// File: rtl/fir_odd_bank.sv
module fir_odd_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_ODD = 8,
  parameter int ODD_W   = 12
) (
  input  logic [DATA_W-1:0]              x,
  output logic [NUM_ODD-1:0][ODD_W-1:0]  odd
);

  logic [ODD_W-1:0] x_ext;
  logic [ODD_W-1:0] x_dbl;
  logic [ODD_W-1:0] run;

  assign x_ext = {{(ODD_W - DATA_W){x[DATA_W-1]}}, x};
  assign x_dbl = x_ext << 1;

  // odd[j] = (2j+1)*x, each one adder above the previous
  always_comb begin
    run = x_ext;
    for (int j = 0; j < NUM_ODD; j++) begin
      odd[j] = run;
      run    = run + x_dbl;
    end
  end

endmodule

// File: rtl/fir_tap_mult.sv
module fir_tap_mult
  import fir_pkg::*;
#(
  parameter int MAG_W   = 8,
  parameter int NUM_ODD = 8,
  parameter int ODD_W   = 12,
  parameter int PROD_W  = 17
) (
  input  logic [NUM_ODD-1:0][ODD_W-1:0] odd,
  input  logic [MAG_W-1:0]              mag,
  output logic signed [PROD_W-1:0]      prod
);

  localparam int NDIG  = MAG_W / DIG_W;
  localparam int IDX_W = (NUM_ODD > 1) ? $clog2(NUM_ODD) : 1;

  logic [DIG_W-1:0] dig;
  logic [IDX_W-1:0] sel_idx;
  logic [ODD_W-1:0] sel;
  int unsigned      sh;

  always_comb begin
    prod    = '0;
    dig     = '0;
    sel_idx = '0;
    sel     = '0;
    sh      = 0;
    for (int d = 0; d < NDIG; d++) begin
      dig     = mag[d*DIG_W +: DIG_W];
      sh      = dig_shift(dig);
      sel_idx = IDX_W'(dig_odd_idx(dig));
      sel     = odd[sel_idx];
      if (dig != '0)
        prod = prod + ({{(PROD_W - ODD_W){sel[ODD_W-1]}}, sel} << (sh + d * DIG_W));
    end
  end

endmodule

// File: rtl/fir_tap_stage.sv
module fir_tap_stage #(
  parameter int PROD_W = 17,
  parameter int ACC_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     neg,
  input  logic signed [PROD_W-1:0] prod,
  input  logic signed [ACC_W-1:0]  chain_in,
  output logic signed [ACC_W-1:0]  acc_q
);

  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] contrib;
  logic signed [ACC_W-1:0] acc_nxt;
  logic        [ACC_W:0]   sum_wide;

  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign contrib  = neg ? -prod_ext : prod_ext;
  assign acc_nxt  = chain_in + contrib;
  assign sum_wide = {contrib[ACC_W-1], contrib} + {chain_in[ACC_W-1], chain_in};

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (sum_wide[ACC_W] == sum_wide[ACC_W-1]));

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/prog_fir_tf.sv
module prog_fir_tf
  import fir_pkg::*;
#(
  parameter int N_TAPS = 8,
  parameter int DATA_W = 8,
  parameter int MAG_W  = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic [DATA_W-1:0]                            in_sample,
  input  logic                                         coef_we,
  input  logic [((N_TAPS > 1) ? $clog2(N_TAPS) : 1)-1:0] coef_idx,
  input  logic                                         coef_neg,
  input  logic [MAG_W-1:0]                             coef_mag,
  output logic                                         out_valid,
  output logic [DATA_W+MAG_W+$clog2(N_TAPS)+1-1:0]     out_sample
);

  localparam int IDX_W   = (N_TAPS > 1) ? $clog2(N_TAPS) : 1;
  localparam int ACC_W   = DATA_W + MAG_W + $clog2(N_TAPS) + 1;
  localparam int NUM_ODD = 1 << (DIG_W - 1);
  localparam int ODD_W   = DATA_W + DIG_W;
  localparam int PROD_W  = DATA_W + MAG_W + 1;

  logic [N_TAPS-1:0][MAG_W-1:0]  mag_q;
  logic [N_TAPS-1:0]             neg_q;
  logic [NUM_ODD-1:0][ODD_W-1:0] odd_mul;
  logic [N_TAPS-1:0][PROD_W-1:0] prod;
  logic [N_TAPS:0][ACC_W-1:0]    acc;
  logic                          idx_ok;

  assign idx_ok = (32'(coef_idx) < N_TAPS);

  // coefficient store: sign-magnitude per tap
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= '0;
    end else if (coef_we && idx_ok) begin
      mag_q[coef_idx] <= coef_mag;
      neg_q[coef_idx] <= coef_neg;
    end
  end

  fir_odd_bank #(
    .DATA_W (DATA_W),
    .NUM_ODD(NUM_ODD),
    .ODD_W  (ODD_W)
  ) u_odd_bank (
    .x  (in_sample),
    .odd(odd_mul)
  );

  assign acc[N_TAPS] = '0;

  for (genvar k = 0; k < N_TAPS; k++) begin : gen_tap
    fir_tap_mult #(
      .MAG_W  (MAG_W),
      .NUM_ODD(NUM_ODD),
      .ODD_W  (ODD_W),
      .PROD_W (PROD_W)
    ) u_mult (
      .odd (odd_mul),
      .mag (mag_q[k]),
      .prod(prod[k])
    );

    fir_tap_stage #(
      .PROD_W(PROD_W),
      .ACC_W (ACC_W)
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .en      (in_valid),
      .neg     (neg_q[k]),
      .prod    (prod[k]),
      .chain_in(acc[k+1]),
      .acc_q   (acc[k])
    );

    // R8
    prod_chk: assert property (@(posedge clk) disable iff (rst)
      $signed(prod[k]) == $signed({1'b0, mag_q[k]}) * $signed(in_sample));
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_sample = acc[0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_sample == '0 && !out_valid && mag_q == '0));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_low_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample));

  // R5
  coef_store_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_we && idx_ok) |=> (mag_q[$past(coef_idx)] == $past(coef_mag)
                             && neg_q[$past(coef_idx)] == $past(coef_neg)));

endmodule

// File: tb/test_prog_fir_tf.sv
module test_prog_fir_tf;

  localparam int N     = 8;
  localparam int ACC_W = 8 + 8 + $clog2(N) + 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [7:0]       in_sample;
  logic             coef_we;
  logic [2:0]       coef_idx;
  logic             coef_neg;
  logic [7:0]       coef_mag;
  logic             out_valid;
  logic [ACC_W-1:0] out_sample;

  always #5 clk = ~clk;

  prog_fir_tf i_prog_fir_tf (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .coef_we   (coef_we),
    .coef_idx  (coef_idx),
    .coef_neg  (coef_neg),
    .coef_mag  (coef_mag),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model: current coefficients and per-sample snapshots
  int cm [N];
  int hx [N];
  int hc [N][N];
  int last_out;

  function automatic int model_out();
    int s = 0;
    for (int k = 0; k < N; k++) s += hc[k][k] * hx[k];
    return s;
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < N; k++) begin
      cm[k] = 0;
      hx[k] = 0;
      for (int j = 0; j < N; j++) hc[k][j] = 0;
    end
    last_out = 0;
  endfunction

  function automatic void model_push(int x);
    for (int k = N - 1; k > 0; k--) begin
      hx[k] = hx[k-1];
      hc[k] = hc[k-1];
    end
    hx[0] = x;
    hc[0] = cm;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cycle(bit v, int x, bit we, int idx, bit neg, int mag, string req);
    int act;
    in_valid  = v;
    in_sample = v ? 8'(x) : 8'($urandom);
    coef_we   = we;
    coef_idx  = 3'(idx);
    coef_neg  = we ? neg : 1'($urandom);
    coef_mag  = we ? 8'(mag) : 8'($urandom);
    @(posedge clk);
    if (v) begin
      model_push(x);
      last_out = model_out();
    end
    if (we) cm[idx] = neg ? -mag : mag;
    @(negedge clk);
    in_valid  = 1'b0;
    coef_we   = 1'b0;
    in_sample = 8'($urandom);
    act = $signed(out_sample);
    check(out_valid == v, "R2", "out_valid", int'(out_valid), int'(v));
    check(act == last_out, req, v ? "output" : "held output", act, last_out);
  endtask

  task automatic sample(int x, string req);
    cycle(1'b1, x, 1'b0, 0, 1'b0, 0, req);
  endtask

  task automatic wr(int idx, int c, string req);
    cycle(1'b0, 0, 1'b1, idx, c < 0, (c < 0) ? -c : c, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check($signed(out_sample) == 0, "R1", "output after reset", $signed(out_sample), 0);
  endtask

  int imp [N] = '{1, 3, -6, 40, -128, 255, 85, 0};

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; in_valid = 0; in_sample = 0;
    coef_we = 0; coef_idx = 0; coef_neg = 0; coef_mag = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    do_reset();

    // R8: impulse reads out each coefficient, newest tap first
    for (int k = 0; k < N; k++) wr(k, imp[k], "R5");
    cycle(1'b0, 0, 1'b1, 7, 1'b1, 0, "R4");     // negative zero on tap 7
    sample(1, "R8");
    for (int k = 1; k < N; k++) sample(0, (k == 2) ? "R4" : "R8");
    sample(0, "R4");                            // negative zero tap contributes nothing
    sample(-1, "R8");
    for (int k = 1; k < N; k++) sample(0, "R8");

    // R7: idle cycles with noisy inputs
    sample(77, "R3");
    for (int k = 0; k < 5; k++) cycle(1'b0, 0, 1'b0, 0, 1'b0, 0, "R7");
    sample(-33, "R7");

    // R6: full-scale magnitude, most negative input
    for (int k = 0; k < N; k++) wr(k, -255, "R6");
    for (int k = 0; k < N; k++) sample(-128, "R6");
    for (int k = 0; k < N; k++) wr(k, 255, "R6");
    for (int k = 0; k < N; k++) sample(-128, "R6");
    for (int k = 0; k < N; k++) sample(127, "R6");

    // R5: write in the same cycle as a sample, then mid-stream writes
    cycle(1'b1, 50, 1'b1, 0, 1'b1, 9, "R5");
    sample(50, "R5");
    cycle(1'b1, -7, 1'b1, 3, 1'b0, 2, "R5");
    for (int k = 0; k < N; k++) sample(k * 11 - 40, "R5");

    // R3/R5: random stream with random writes and idle gaps
    for (int i = 0; i < 600; i++) begin
      bit v  = ($urandom_range(9) < 7);
      bit we = ($urandom_range(9) < 2);
      int x  = int'($urandom_range(255)) - 128;
      int m;
      case ($urandom_range(5))
        0:       m = 0;
        1:       m = 255;
        default: m = int'($urandom_range(255));
      endcase
      cycle(v, x, we, int'($urandom_range(N - 1)), 1'($urandom), m, we ? "R5" : "R3");
    end

    // R1: reset mid-run clears coefficients and partial sums
    do_reset();
    wr(1, 5, "R1");
    sample(3, "R1");
    sample(0, "R1");
    sample(0, "R1");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule